// File: doc/BRIEF.md
# I2C Master Chunked Transfer Sequencer

This block sits between a streaming byte source (valid/ready) and a byte-level I2C master engine. It moves long write transfers through a byte-count register that holds at most 255 bytes. The transfer is cut into chunks. A command gives the total length, says whether to open with a START and address phase, and picks the end mode. The block loads the first chunk by itself. When a chunk runs out and bytes remain, it stalls the bus and raises a reload flag. Software must then supply the size of the next chunk.

Later chunks resume with no START and no STOP between them. After the final byte there are two end modes. In automatic mode a STOP is issued at once. In software mode the block raises a completion flag and holds the bus. It then waits for either a stop request or a new command, and the new command produces a repeated START. Status flags stay set until they are cleared by writing a 1 to the clear input.

Top module: `i2c_chunk_sequencer`

## Requirements
- R1: While reset is asserted, and after it, the block is idle. `busy_o`, `src_ready_o`, `eng_byte_valid_o`, `eng_start_o`, `eng_stop_o` and all `flags_o` bits are 0.
- R2: When idle, a command with a nonzero length starts the transfer. If `cmd_start_i`=1, `eng_start_o` pulses for exactly one cycle on the cycle after the command, and bytes flow in the cycle after that. If `cmd_start_i`=0, bytes flow on the cycle after the command with no START. During the transfer `src_ready_o` = `eng_ack_i`, `eng_byte_valid_o` = `src_valid_i`, and `eng_byte_o` = `src_data_i`.
- R3: The first chunk is min(length, 255) bytes. When a chunk ends with bytes still remaining, `flags_o[0]` (reload pending) is set. The source is then not popped and no byte is offered until a valid reload is written.
- R4: A reload count that is nonzero and no larger than the bytes remaining resumes the transfer with no START or STOP, and clears `flags_o[0]` in the same cycle.
- R5: A reload count of zero, or one larger than the bytes remaining, sets `flags_o[3]` (error). No byte moves, and the reload stays pending.
- R6: In automatic-end mode (`cmd_autoend_i`=1), `eng_stop_o` pulses for one cycle on the cycle after the final byte's handshake. On the next cycle `flags_o[2]` (stop issued) is set and `busy_o` falls.
- R7: In software-end mode, the final byte sets `flags_o[1]` (complete). No STOP is issued, and nothing is popped while waiting. A `swstop_i` pulse then issues a one-cycle `eng_stop_o` on the next cycle.
- R8: While waiting after a software-end completion, a new nonzero command takes priority over `swstop_i`. It issues a repeated START with no STOP before it.
- R9: A command of length zero sets `flags_o[3]`, issues no START and leaves the block idle.
- R10: Each `flags_o` bit is cleared by a 1 on the same bit of `flags_clr_i`. A set event in the same cycle wins over the clear.
- R11: A command that arrives while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_len_i | input | LEN_W | Total bytes of the transfer |
| cmd_start_i | input | 1 | 1: open with START and address |
| cmd_autoend_i | input | 1 | 1: automatic STOP, 0: software end |
| reload_valid_i | input | 1 | Reload count strobe |
| reload_cnt_i | input | CNT_W | Size of the next chunk |
| swstop_i | input | 1 | Software stop request |
| src_valid_i | input | 1 | Source byte available |
| src_data_i | input | DATA_W | Source byte |
| src_ready_o | output | 1 | Source byte popped when high with valid |
| eng_start_o | output | 1 | Engine: issue START and address |
| eng_stop_o | output | 1 | Engine: issue STOP |
| eng_byte_valid_o | output | 1 | Engine: byte offered |
| eng_byte_o | output | DATA_W | Engine: byte to send |
| eng_ack_i | input | 1 | Engine accepts the offered byte |
| flags_clr_i | input | 4 | Write-1-to-clear for flags_o |
| flags_o | output | 4 | [0] reload, [1] complete, [2] stop issued, [3] error |
| busy_o | output | 1 | A transfer or pending end is in progress |

## Verification
The assertions assume the engine raises `eng_ack_i` only as a byte acceptance. They also assume software writes reloads and stop requests only as single-cycle strobes. The bench drives every strobe for exactly one cycle on the falling edge. In the table-driven runs it holds `eng_ack_i` high. It stalls the flow only through `src_valid_i`. It picks each reload count from its own running tally of popped bytes, except in the error tests, which deliberately write out-of-range counts.

// File: rtl/i2c_chunk_pkg.sv
package i2c_chunk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_XFER,
    ST_RELOAD,
    ST_SWWAIT,
    ST_STOP
  } seq_state_e;

  localparam int FLAG_W      = 4;
  localparam int FLAG_RELOAD = 0;
  localparam int FLAG_DONE   = 1;
  localparam int FLAG_STOP   = 2;
  localparam int FLAG_ERR    = 3;

endpackage

// File: rtl/i2c_chunk_rst_sync.sv
module i2c_chunk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/i2c_chunk_count.sv
module i2c_chunk_count #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_total_i,
  input  logic [LEN_W-1:0] total_i,
  input  logic             load_chunk_i,
  input  logic [CNT_W-1:0] chunk_i,
  input  logic             byte_done_i,
  output logic             chunk_last_o,
  output logic             remain_last_o,
  output logic             reload_bad_o
);
  localparam logic [LEN_W-1:0] CHUNK_MAX = LEN_W'((1 << CNT_W) - 1);

  logic [LEN_W-1:0] remain_q, remain_d;
  logic [CNT_W-1:0] chunk_q, chunk_d;
  logic             cnt_en;

  always_comb begin
    remain_d = remain_q;
    chunk_d  = chunk_q;
    if (load_total_i) begin
      remain_d = total_i;
      chunk_d  = (total_i > CHUNK_MAX) ? CNT_W'(CHUNK_MAX) : CNT_W'(total_i);
    end else if (load_chunk_i) begin
      chunk_d = chunk_i;
    end else if (byte_done_i) begin
      remain_d = remain_q - 1'b1;
      chunk_d  = chunk_q - 1'b1;
    end
  end

  assign cnt_en = load_total_i | load_chunk_i | byte_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      chunk_q  <= '0;
    end else if (cnt_en) begin
      remain_q <= remain_d;
      chunk_q  <= chunk_d;
    end
  end

  assign chunk_last_o  = (chunk_q == CNT_W'(1));
  assign remain_last_o = (remain_q == LEN_W'(1));
  assign reload_bad_o  = (chunk_i == '0) || (LEN_W'(chunk_i) > remain_q);
endmodule

// File: rtl/i2c_chunk_fsm.sv
module i2c_chunk_fsm
  import i2c_chunk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic       cmd_len_zero_i,
  input  logic       cmd_start_i,
  input  logic       cmd_autoend_i,
  input  logic       reload_valid_i,
  input  logic       reload_bad_i,
  input  logic       swstop_i,
  input  logic       byte_done_i,
  input  logic       chunk_last_i,
  input  logic       remain_last_i,
  output seq_state_e state_o,
  output logic       load_total_o,
  output logic       load_chunk_o,
  output logic       ev_reload_o,
  output logic       ev_done_o,
  output logic       ev_stop_o,
  output logic       ev_err_o
);
  seq_state_e state_q, state_d;
  logic       autoend_q, autoend_d;
  logic       cmd_open, cmd_ok;

  assign cmd_open = (state_q == ST_IDLE) || (state_q == ST_SWWAIT);
  assign cmd_ok   = cmd_open && cmd_valid_i && !cmd_len_zero_i;

  always_comb begin
    state_d      = state_q;
    autoend_d    = autoend_q;
    load_total_o = 1'b0;
    load_chunk_o = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_SWWAIT: begin
        if (cmd_ok) begin
          load_total_o = 1'b1;
          autoend_d    = cmd_autoend_i;
          state_d      = cmd_start_i ? ST_START : ST_XFER;
        end else if ((state_q == ST_SWWAIT) && swstop_i) begin
          state_d = ST_STOP;
        end
      end
      ST_START: state_d = ST_XFER;
      ST_XFER: begin
        if (byte_done_i && chunk_last_i) begin
          if (!remain_last_i) state_d = ST_RELOAD;
          else if (autoend_q) state_d = ST_STOP;
          else                state_d = ST_SWWAIT;
        end
      end
      ST_RELOAD: begin
        if (reload_valid_i && !reload_bad_i) begin
          load_chunk_o = 1'b1;
          state_d      = ST_XFER;
        end
      end
      ST_STOP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      autoend_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      autoend_q <= autoend_d;
    end
  end

  assign state_o     = state_q;
  assign ev_reload_o = (state_q == ST_XFER) && (state_d == ST_RELOAD);
  assign ev_done_o   = (state_q == ST_XFER) && (state_d == ST_SWWAIT);
  assign ev_stop_o   = (state_q == ST_STOP);
  assign ev_err_o    = (cmd_open && cmd_valid_i && cmd_len_zero_i) ||
                       ((state_q == ST_RELOAD) && reload_valid_i && reload_bad_i);
endmodule

// File: rtl/i2c_chunk_flags.sv
module i2c_chunk_flags #(
  parameter int NUM = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] set_i,
  input  logic [NUM-1:0] clr_i,
  output logic [NUM-1:0] flags_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_flag
    logic flag_q, flag_d, flag_en;
    assign flag_en = set_i[g] | clr_i[g];
    assign flag_d  = set_i[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_q <= 1'b0;
      else if (flag_en) flag_q <= flag_d;
    end
    assign flags_o[g] = flag_q;
  end
endmodule

// File: rtl/i2c_chunk_sequencer.sv
module i2c_chunk_sequencer
  import i2c_chunk_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic              cmd_start_i,
  input  logic              cmd_autoend_i,
  input  logic              reload_valid_i,
  input  logic [CNT_W-1:0]  reload_cnt_i,
  input  logic              swstop_i,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ready_o,
  output logic              eng_start_o,
  output logic              eng_stop_o,
  output logic              eng_byte_valid_o,
  output logic [DATA_W-1:0] eng_byte_o,
  input  logic              eng_ack_i,
  input  logic [3:0]        flags_clr_i,
  output logic [3:0]        flags_o,
  output logic              busy_o
);
  logic       rst_sync_n;
  seq_state_e state;
  logic       moving, byte_done;
  logic       load_total, load_chunk;
  logic       chunk_last, remain_last, reload_bad;
  logic       ev_reload, ev_done, ev_stop, ev_err;
  logic [FLAG_W-1:0] flag_set, flag_clr;

  i2c_chunk_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  i2c_chunk_count #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .load_total_i  (load_total),
    .total_i       (cmd_len_i),
    .load_chunk_i  (load_chunk),
    .chunk_i       (reload_cnt_i),
    .byte_done_i   (byte_done),
    .chunk_last_o  (chunk_last),
    .remain_last_o (remain_last),
    .reload_bad_o  (reload_bad)
  );

  i2c_chunk_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_sync_n),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_len_zero_i (cmd_len_i == '0),
    .cmd_start_i    (cmd_start_i),
    .cmd_autoend_i  (cmd_autoend_i),
    .reload_valid_i (reload_valid_i),
    .reload_bad_i   (reload_bad),
    .swstop_i       (swstop_i),
    .byte_done_i    (byte_done),
    .chunk_last_i   (chunk_last),
    .remain_last_i  (remain_last),
    .state_o        (state),
    .load_total_o   (load_total),
    .load_chunk_o   (load_chunk),
    .ev_reload_o    (ev_reload),
    .ev_done_o      (ev_done),
    .ev_stop_o      (ev_stop),
    .ev_err_o       (ev_err)
  );

  always_comb begin
    flag_set              = '0;
    flag_set[FLAG_RELOAD] = ev_reload;
    flag_set[FLAG_DONE]   = ev_done;
    flag_set[FLAG_STOP]   = ev_stop;
    flag_set[FLAG_ERR]    = ev_err;
    flag_clr              = flags_clr_i;
    flag_clr[FLAG_RELOAD] = flags_clr_i[FLAG_RELOAD] | load_chunk;
  end

  i2c_chunk_flags #(.NUM(FLAG_W)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_o (flags_o)
  );

  assign moving           = (state == ST_XFER);
  assign byte_done        = moving & src_valid_i & eng_ack_i;
  assign src_ready_o      = moving & eng_ack_i;
  assign eng_byte_valid_o = moving & src_valid_i;
  assign eng_byte_o       = src_data_i;
  assign eng_start_o      = (state == ST_START);
  assign eng_stop_o       = (state == ST_STOP);
  assign busy_o           = (state != ST_IDLE);
endmodule

// File: rtl/i2c_chunk_sequencer_chk.sv
module i2c_chunk_sequencer_chk
  import i2c_chunk_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input seq_state_e       state,
  input logic             cmd_valid_i,
  input logic [LEN_W-1:0] cmd_len_i,
  input logic             cmd_start_i,
  input logic             reload_valid_i,
  input logic [CNT_W-1:0] reload_cnt_i,
  input logic             src_ready_o,
  input logic             eng_byte_valid_o,
  input logic             eng_ack_i,
  input logic             eng_start_o,
  input logic             eng_stop_o,
  input logic [3:0]       flags_clr_i,
  input logic [3:0]       flags_o
);
  a_r2_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  a_r2_ready_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> eng_ack_i);

  a_r3_hold_on_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RELOAD) |-> (!src_ready_o && !eng_byte_valid_o));

  a_r4_no_edge_after_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RELOAD) |=> (!eng_start_o && !eng_stop_o));

  a_r5_zero_reload_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RELOAD && reload_valid_i && reload_cnt_i == '0) |=> flags_o[3]);

  a_r6_stop_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_stop_o |=> !eng_stop_o);

  a_r7_hold_on_swwait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SWWAIT) |-> (!src_ready_o && !eng_byte_valid_o && !eng_stop_o));

  a_r8_repeated_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SWWAIT && cmd_valid_i && cmd_len_i != '0 && cmd_start_i) |=> eng_start_o);

  a_r9_zero_len_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && cmd_valid_i && cmd_len_i == '0) |=> (!eng_start_o && flags_o[3]));

  a_r10_stop_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[2] && flags_clr_i[2] && !eng_stop_o) |=> !flags_o[2]);

  a_r11_busy_cmd_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_XFER && cmd_valid_i) |=> !eng_start_o);
endmodule

bind i2c_chunk_sequencer i2c_chunk_sequencer_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .state            (state),
  .cmd_valid_i      (cmd_valid_i),
  .cmd_len_i        (cmd_len_i),
  .cmd_start_i      (cmd_start_i),
  .reload_valid_i   (reload_valid_i),
  .reload_cnt_i     (reload_cnt_i),
  .src_ready_o      (src_ready_o),
  .eng_byte_valid_o (eng_byte_valid_o),
  .eng_ack_i        (eng_ack_i),
  .eng_start_o      (eng_start_o),
  .eng_stop_o       (eng_stop_o),
  .flags_clr_i      (flags_clr_i),
  .flags_o          (flags_o)
);

// File: tb/test_i2c_chunk_sequencer.sv
module test_i2c_chunk_sequencer;
  localparam int LEN_W = 16;
  localparam int CNT_W = 8;
  localparam int DATA_W = 8;
  localparam int NV = 6;
  // {autoend, length}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 16'd1}, {1'b1, 16'd255}, {1'b0, 16'd256},
    {1'b1, 16'd600}, {1'b0, 16'd510}, {1'b0, 16'd7}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0, cmd_start_i = 1'b0, cmd_autoend_i = 1'b0;
  logic [LEN_W-1:0] cmd_len_i = '0;
  logic reload_valid_i = 1'b0;
  logic [CNT_W-1:0] reload_cnt_i = '0;
  logic swstop_i = 1'b0, src_valid_i = 1'b1, eng_ack_i = 1'b1;
  logic [DATA_W-1:0] src_data_i = 8'hA5;
  logic [3:0] flags_clr_i = '0;
  logic src_ready_o, eng_start_o, eng_stop_o, eng_byte_valid_o, busy_o;
  logic [DATA_W-1:0] eng_byte_o;
  logic [3:0] flags_o;

  int checks = 0, fails = 0, cyc = 0;
  int pops = 0, starts = 0, stops = 0;
  int pb, sb, tb_stops;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_chunk_sequencer #(.LEN_W(LEN_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_i2c_chunk_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_len_i(cmd_len_i),
    .cmd_start_i(cmd_start_i), .cmd_autoend_i(cmd_autoend_i),
    .reload_valid_i(reload_valid_i), .reload_cnt_i(reload_cnt_i), .swstop_i(swstop_i),
    .src_valid_i(src_valid_i), .src_data_i(src_data_i), .src_ready_o(src_ready_o),
    .eng_start_o(eng_start_o), .eng_stop_o(eng_stop_o), .eng_byte_valid_o(eng_byte_valid_o),
    .eng_byte_o(eng_byte_o), .eng_ack_i(eng_ack_i), .flags_clr_i(flags_clr_i),
    .flags_o(flags_o), .busy_o(busy_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (src_ready_o && src_valid_i) pops <= pops + 1;
    if (eng_start_o) starts <= starts + 1;
    if (eng_stop_o) stops <= stops + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_cmd(input int len, input bit st, input bit ae);
    cmd_valid_i = 1'b1; cmd_len_i = LEN_W'(len); cmd_start_i = st; cmd_autoend_i = ae;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic reload(input int n);
    reload_valid_i = 1'b1; reload_cnt_i = CNT_W'(n);
    @(negedge clk);
    reload_valid_i = 1'b0;
  endtask

  task automatic clr(input logic [3:0] m);
    flags_clr_i = m;
    @(negedge clk);
    flags_clr_i = '0;
  endtask

  task automatic wait_flag(input int idx);
    for (int g = 0; g < 3000 && !flags_o[idx]; g++) @(negedge clk);
  endtask

  task automatic run_to_end(input int len, output int n_rel, output int n_done);
    n_rel = 0; n_done = 0;
    for (int g = 0; g < 5000 && busy_o; g++) begin
      if (flags_o[0]) begin
        int rem = len - (pops - pb);
        n_rel++;
        reload(rem > 255 ? 255 : rem);
      end else if (flags_o[1]) begin
        n_done++;
        swstop_i = 1'b1; flags_clr_i = 4'b0010;
        @(negedge clk);
        swstop_i = 1'b0; flags_clr_i = '0;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    int nr, nd;
    tick(3);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 flags", flags_o, 0);
    chk("R1 ready", src_ready_o, 0);
    chk("R1 start/stop", {eng_start_o, eng_stop_o}, 0);
    rst_ni = 1'b1;
    tick(4);
    chk("R1 idle after release", {busy_o, flags_o}, 0);

    // table walk: full transfers with reloads and both end modes (R3, R4, R6, R7)
    for (int v = 0; v < NV; v++) begin
      int len = int'(VEC[v][15:0]);
      bit ae = VEC[v][16];
      pb = pops; sb = starts; tb_stops = stops;
      send_cmd(len, 1'b1, ae);
      run_to_end(len, nr, nd);
      tick(1);
      chk("R3 bytes moved", pops - pb, len);
      chk("R2 one start", starts - sb, 1);
      chk("R6 one stop", stops - tb_stops, 1);
      chk("R3 reload count", nr, (len - 1) / 255);
      chk("R7 completion count", nd, ae ? 0 : 1);
      clr(4'hF);
    end

    // R2 and R6 cycle timing
    pb = pops; src_data_i = 8'h3C;
    send_cmd(3, 1'b1, 1'b1);
    chk("R2 start pulse", eng_start_o, 1);
    chk("R2 no pop during start", src_ready_o, 0);
    tick(1);
    chk("R2 start ends", eng_start_o, 0);
    chk("R2 flowing", {src_ready_o, eng_byte_valid_o}, 2'b11);
    chk("R2 byte passed", eng_byte_o, 8'h3C);
    tick(3);
    chk("R6 stop pulse", eng_stop_o, 1);
    tick(1);
    chk("R6 stop ends", eng_stop_o, 0);
    chk("R6 stop flag", flags_o[2], 1);
    chk("R6 idle", busy_o, 0);
    chk("R6 bytes", pops - pb, 3);
    clr(4'b0100);
    chk("R10 stop flag cleared", flags_o[2], 0);

    // R2 without START
    pb = pops; sb = starts;
    send_cmd(2, 1'b0, 1'b1);
    chk("R2 no start option", eng_start_o, 0);
    chk("R2 no start flows", src_ready_o, 1);
    run_to_end(2, nr, nd);
    chk("R2 no start count", starts - sb, 0);
    clr(4'hF);

    // R9 zero length
    sb = starts;
    send_cmd(0, 1'b1, 1'b1);
    chk("R9 err flag", flags_o[3], 1);
    chk("R9 stays idle", busy_o, 0);
    tick(1);
    chk("R9 no start", starts - sb, 0);
    clr(4'b1000);
    chk("R10 err cleared", flags_o[3], 0);

    // R3, R5, R4 on a 300-byte transfer
    pb = pops; sb = starts; tb_stops = stops;
    send_cmd(300, 1'b1, 1'b1);
    wait_flag(0);
    chk("R3 first chunk", pops - pb, 255);
    chk("R3 held", {src_ready_o, eng_byte_valid_o}, 0);
    tick(3);
    chk("R3 no pop while pending", pops - pb, 255);
    reload(0);
    chk("R5 zero reload err", flags_o[3], 1);
    chk("R5 still pending", flags_o[0], 1);
    tick(1);
    chk("R5 no data", pops - pb, 255);
    clr(4'b1000);
    reload(46);
    chk("R5 oversize reload err", flags_o[3], 1);
    chk("R5 oversize still held", src_ready_o, 0);
    clr(4'b1000);
    reload(45);
    chk("R4 reload clears flag", flags_o[0], 0);
    chk("R4 resumes", src_ready_o, 1);
    run_to_end(300, nr, nd);
    tick(1);
    chk("R4 total bytes", pops - pb, 300);
    chk("R4 no restart", starts - sb, 1);
    chk("R4 single stop", stops - tb_stops, 1);
    clr(4'hF);

    // R7 and R8 software end with repeated start
    pb = pops; sb = starts; tb_stops = stops;
    send_cmd(2, 1'b1, 1'b0);
    wait_flag(1);
    chk("R7 bytes", pops - pb, 2);
    chk("R7 no stop", stops - tb_stops, 0);
    tick(2);
    chk("R7 no pop while waiting", pops - pb, 2);
    chk("R7 still busy", busy_o, 1);
    swstop_i = 1'b1;
    send_cmd(1, 1'b1, 1'b0);
    swstop_i = 1'b0;
    chk("R8 repeated start", eng_start_o, 1);
    chk("R8 no stop before", eng_stop_o, 0);
    clr(4'b0010);
    wait_flag(1);
    swstop_i = 1'b1;
    @(negedge clk);
    swstop_i = 1'b0;
    chk("R7 sw stop pulse", eng_stop_o, 1);
    tick(1);
    chk("R7 idle after stop", busy_o, 0);
    chk("R8 starts", starts - sb, 2);
    chk("R8 stops", stops - tb_stops, 1);
    clr(4'hF);

    // R11 command while busy
    pb = pops; sb = starts;
    src_valid_i = 1'b0;
    send_cmd(4, 1'b1, 1'b1);
    tick(1);
    send_cmd(9, 1'b1, 1'b1);
    chk("R11 no start", eng_start_o, 0);
    src_valid_i = 1'b1;
    run_to_end(4, nr, nd);
    tick(1);
    chk("R11 bytes unchanged", pops - pb, 4);
    chk("R11 starts", starts - sb, 1);
    clr(4'hF);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule